// File: doc/BRIEF.md
# Indirect Memory and Peripheral Access Window

This block gives a host a small set of registers through which it reaches two spaces that are not mapped directly: a word-organised internal SRAM and an internal peripheral register space. The host first loads an address register and then touches a data register. The data access performs the real transfer and returns a ready pulse when it is complete. Memory has separate read and write pointers. Each memory data access moves its own pointer forward by one 32-bit word, so a run of consecutive words can be streamed without reloading the address.

Peripheral accesses use their own pair of address registers, one for writes and one for reads. Each holds a register offset and a byte-count field. The count selects how many byte lanes the transfer covers, starting from lane 0. The block drives a synchronous SRAM port with a read latency of one cycle. It also drives a peripheral request port that holds its request until the peripheral acknowledges it.

The host issues single-cycle requests on `host_req` and waits for `host_ready` before it issues the next request. A request that arrives while a memory or peripheral transfer is in flight is dropped.

Top module: `idx_mem_window`

## Requirements
- R1: After a synchronous active-low reset, `host_ready`, `sram_en` and `prph_req` are low, and both memory pointers read back as zero.
- R2: The register select on `host_sel` is decoded as follows: 0 = memory read pointer, 1 = memory write pointer, 2 = memory write data, 3 = memory read data, 4 = peripheral write address, 5 = peripheral read address, 6 = peripheral write data, 7 = peripheral read data. Writing either pointer stores all 32 bits, and reading the pointer returns them. Pointer and address-register accesses raise `host_ready` one cycle after the request.
- R3: Writing select 2 issues one SRAM write of the data at word address `wptr[MEM_AW+1:2]` and then adds 4 to the write pointer. `host_ready` rises two cycles after the request.
- R4: Reading select 3 issues one single-cycle SRAM read at word address `rptr[MEM_AW+1:2]` and adds 4 to the read pointer. Three cycles after the request, `host_ready` rises with that word on `host_rdata`.
- R5: The read pointer and the write pointer are independent. Memory reads never change the write pointer, and memory writes never change the read pointer, even when the two are interleaved.
- R6: The two low pointer bits take no part in the SRAM address. Pointers advance modulo 2^32, so 0xFFFFFFFC advances to 0.
- R7: A peripheral address register keeps the offset in bits [PRPH_OW-1:0] and the byte count minus one in bits 25:24. All other bits read back as zero.
- R8: Writing select 6 raises `prph_req` with `prph_we`=1, the stored write offset, the write data, and byte enables that cover the lanes from lane 0 up to the count: count 0 gives 0001, count 1 gives 0011, count 2 gives 0111, count 3 gives 1111. All request outputs stay constant until `prph_ack`. `host_ready` rises on the cycle after the acknowledge.
- R9: Reading select 7 issues a peripheral read at the stored read offset, with byte enables taken from that register's count. The data on `prph_rdata` during the acknowledge cycle is returned on `host_rdata` with `host_ready` in the following cycle.
- R10: Writing the read-data registers (selects 3 and 7) causes no SRAM or peripheral access and leaves the pointers unchanged. Reading the write-data registers (selects 2 and 6) returns zero. Both still complete with `host_ready` after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | One-cycle host access request |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_sel | input | 3 | Register select |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid while host_ready is high |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | MEM_AW | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, one cycle after enable |
| prph_req | output | 1 | Peripheral request, held until acknowledge |
| prph_we | output | 1 | Peripheral write enable |
| prph_addr | output | PRPH_OW | Peripheral register offset |
| prph_be | output | 4 | Peripheral byte enables |
| prph_wdata | output | 32 | Peripheral write data |
| prph_ack | input | 1 | Peripheral acknowledge |
| prph_rdata | input | 32 | Peripheral read data, valid with acknowledge |

## Verification
Memory traffic is tested in three patterns. Streaming writes followed by streaming reads expose a missing or doubled pointer increment. Reads and writes interleaved at different addresses expose pointers that share state. Pointers with non-zero low bits, and a pointer sitting at the top of the 32-bit range, show whether the low bits are dropped from the SRAM address and whether the increment wraps. On the peripheral side, writes with every byte count land on one offset and are then read back, which separates correct lane masks from shifted or inverted ones. The acknowledge is delayed by 0, 1 and 2 cycles to show that the request holds steady and that completion follows the acknowledge rather than a fixed delay.

// File: rtl/imw_pkg.sv
// Package: shared register codes, sequencer states and the lane-mask helper
// for the indirect access window. Assumes a 32-bit host data path.
package imw_pkg;

    typedef enum logic [2:0] {
        SEL_MEM_RPTR   = 3'd0,
        SEL_MEM_WPTR   = 3'd1,
        SEL_MEM_WDATA  = 3'd2,
        SEL_MEM_RDATA  = 3'd3,
        SEL_PRPH_WADDR = 3'd4,
        SEL_PRPH_RADDR = 3'd5,
        SEL_PRPH_WDATA = 3'd6,
        SEL_PRPH_RDATA = 3'd7
    } imw_sel_e;

    typedef enum logic [1:0] {
        MS_IDLE     = 2'd0,
        MS_RD_ISSUE = 2'd1,
        MS_RD_CAP   = 2'd2,
        MS_WR_ISSUE = 2'd3
    } mem_state_e;

    localparam int CNT_LSB = 24;

    // Turn a byte count minus one into lane enables, filling from lane 0
    function automatic logic [3:0] lanes_from_count(input logic [1:0] cnt);
        logic [3:0] m;
        for (int k = 0; k < 4; k++) begin
            m[k] = (k <= int'(cnt));
        end
        return m;
    endfunction

endpackage

// File: rtl/imw_ptr.sv
// Module: address pointer with load and post-increment.
// Assumes load and advance are never both requested in one cycle; if they
// are, load wins. The increment wraps modulo 2^W.
module imw_ptr #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         advance,
    output logic [W-1:0] ptr
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    // Pointer register: load from host, else step forward after an access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (advance) begin
            ptr <= ptr + STEP_V;
        end
    end

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (ptr == $past(ptr) + STEP_V));

    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(ptr));

endmodule

// File: rtl/imw_mem_seq.sv
// Module: SRAM access sequencer. It runs one read or write at a time
// against a synchronous SRAM whose read data appears one cycle after enable.
// done pulses for one cycle when the access is complete, and read data
// travels with done.
module imw_mem_seq #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_start,
    input  logic          wr_start,
    input  logic [AW-1:0] rd_word,
    input  logic [AW-1:0] wr_word,
    input  logic [DW-1:0] wr_data,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          sram_en,
    output logic          sram_we,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_wdata,
    input  logic [DW-1:0] sram_rdata
);
    import imw_pkg::*;

    mem_state_e state;

    // Access state machine: issue, wait one cycle for read data, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= MS_IDLE;
            sram_en    <= 1'b0;
            sram_we    <= 1'b0;
            sram_addr  <= '0;
            sram_wdata <= '0;
        end else begin
            case (state)
                MS_IDLE: begin
                    if (rd_start) begin
                        sram_en   <= 1'b1;
                        sram_we   <= 1'b0;
                        sram_addr <= rd_word;
                        state     <= MS_RD_ISSUE;
                    end else if (wr_start) begin
                        sram_en    <= 1'b1;
                        sram_we    <= 1'b1;
                        sram_addr  <= wr_word;
                        sram_wdata <= wr_data;
                        state      <= MS_WR_ISSUE;
                    end
                end
                MS_RD_ISSUE: begin
                    sram_en <= 1'b0;
                    state   <= MS_RD_CAP;
                end
                MS_RD_CAP: begin
                    state <= MS_IDLE;
                end
                default: begin
                    sram_en <= 1'b0;
                    sram_we <= 1'b0;
                    state   <= MS_IDLE;
                end
            endcase
        end
    end

    // Completion flags and read data path
    always_comb begin
        busy    = (state != MS_IDLE);
        done    = (state == MS_RD_CAP) || (state == MS_WR_ISSUE);
        rd_data = (state == MS_RD_CAP) ? sram_rdata : '0;
    end

    assert_read_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && !sram_we) |=> (!sram_en && done));

    assert_write_completes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && sram_we) |-> done);

endmodule

// File: rtl/imw_prph_seq.sv
// Module: peripheral request sequencer. It raises one request and holds
// every request field until the peripheral acknowledges it. Assumes
// prph_rdata is valid in the acknowledge cycle.
module imw_prph_seq #(
    parameter int OW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_write,
    input  logic [OW-1:0] off,
    input  logic [1:0]    cnt,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          prph_req,
    output logic          prph_we,
    output logic [OW-1:0] prph_addr,
    output logic [3:0]    prph_be,
    output logic [DW-1:0] prph_wdata,
    input  logic          prph_ack,
    input  logic [DW-1:0] prph_rdata
);
    import imw_pkg::*;

    // Request register: load on start, release on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            prph_req   <= 1'b0;
            prph_we    <= 1'b0;
            prph_addr  <= '0;
            prph_be    <= '0;
            prph_wdata <= '0;
        end else if (!busy) begin
            if (start) begin
                busy       <= 1'b1;
                prph_req   <= 1'b1;
                prph_we    <= is_write;
                prph_addr  <= off;
                prph_be    <= lanes_from_count(cnt);
                prph_wdata <= is_write ? wdata : '0;
            end
        end else if (prph_ack) begin
            busy     <= 1'b0;
            prph_req <= 1'b0;
        end
    end

    // Completion pulse and read data returned with it
    always_comb begin
        done    = busy && prph_ack;
        rd_data = (done && !prph_we) ? prph_rdata : '0;
    end

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prph_req && !prph_ack) |=> (prph_req && $stable(prph_addr)
                                     && $stable(prph_be) && $stable(prph_we)
                                     && $stable(prph_wdata)));

    assert_be_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prph_req |-> (prph_be == 4'b0001 || prph_be == 4'b0011 ||
                      prph_be == 4'b0111 || prph_be == 4'b1111));

endmodule

// File: rtl/idx_mem_window.sv
// Module: host register window with indirect, auto-incrementing access to
// an SRAM and to a peripheral register space. Assumes the host issues
// one-cycle requests and waits for host_ready before the next request.
// Requests that arrive while a transfer is in flight are dropped.
module idx_mem_window #(
    parameter int MEM_AW  = 10,
    parameter int PRPH_OW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [2:0]         host_sel,
    input  logic [31:0]        host_wdata,
    output logic               host_ready,
    output logic [31:0]        host_rdata,
    output logic               sram_en,
    output logic               sram_we,
    output logic [MEM_AW-1:0]  sram_addr,
    output logic [31:0]        sram_wdata,
    input  logic [31:0]        sram_rdata,
    output logic               prph_req,
    output logic               prph_we,
    output logic [PRPH_OW-1:0] prph_addr,
    output logic [3:0]         prph_be,
    output logic [31:0]        prph_wdata,
    input  logic               prph_ack,
    input  logic [31:0]        prph_rdata
);
    import imw_pkg::*;

    localparam int DW    = 32;
    localparam int WLSB  = 2;
    localparam int WMSB  = MEM_AW + WLSB - 1;

    logic [DW-1:0]      rptr, wptr;
    logic [PRPH_OW-1:0] pw_off, pr_off;
    logic [1:0]         pw_cnt, pr_cnt;
    logic               mem_busy, mem_done, prph_busy, prph_done;
    logic [DW-1:0]      mem_rd_data, prph_rd_data;
    logic               accept, ld_rptr, ld_wptr, ld_pw, ld_pr;
    logic               mem_wr_go, mem_rd_go, pr_wr_go, pr_rd_go;
    logic               engine_go, simple_go;
    logic [DW-1:0]      pw_view, pr_view, reg_view;

    // Request decode: accept only when no transfer is outstanding
    always_comb begin
        accept    = host_req && !mem_busy && !prph_busy;
        ld_rptr   = accept &&  host_we && (host_sel == SEL_MEM_RPTR);
        ld_wptr   = accept &&  host_we && (host_sel == SEL_MEM_WPTR);
        ld_pw     = accept &&  host_we && (host_sel == SEL_PRPH_WADDR);
        ld_pr     = accept &&  host_we && (host_sel == SEL_PRPH_RADDR);
        mem_wr_go = accept &&  host_we && (host_sel == SEL_MEM_WDATA);
        mem_rd_go = accept && !host_we && (host_sel == SEL_MEM_RDATA);
        pr_wr_go  = accept &&  host_we && (host_sel == SEL_PRPH_WDATA);
        pr_rd_go  = accept && !host_we && (host_sel == SEL_PRPH_RDATA);
        engine_go = mem_wr_go || mem_rd_go || pr_wr_go || pr_rd_go;
        simple_go = accept && !engine_go;
    end

    // Read-back views of the peripheral address registers
    always_comb begin
        pw_view = '0;
        pr_view = '0;
        pw_view[PRPH_OW-1:0]        = pw_off;
        pw_view[CNT_LSB+1:CNT_LSB]  = pw_cnt;
        pr_view[PRPH_OW-1:0]        = pr_off;
        pr_view[CNT_LSB+1:CNT_LSB]  = pr_cnt;
    end

    // Register read mux for accesses that complete in one cycle
    always_comb begin
        case (imw_sel_e'(host_sel))
            SEL_MEM_RPTR:   reg_view = rptr;
            SEL_MEM_WPTR:   reg_view = wptr;
            SEL_PRPH_WADDR: reg_view = pw_view;
            SEL_PRPH_RADDR: reg_view = pr_view;
            default:        reg_view = '0;
        endcase
    end

    // Peripheral address registers keep only the offset and count fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_off <= '0;
            pw_cnt <= '0;
            pr_off <= '0;
            pr_cnt <= '0;
        end else begin
            if (ld_pw) begin
                pw_off <= host_wdata[PRPH_OW-1:0];
                pw_cnt <= host_wdata[CNT_LSB+1:CNT_LSB];
            end
            if (ld_pr) begin
                pr_off <= host_wdata[PRPH_OW-1:0];
                pr_cnt <= host_wdata[CNT_LSB+1:CNT_LSB];
            end
        end
    end

    // Completion pulse and returned data toward the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ready <= 1'b0;
            host_rdata <= '0;
        end else if (simple_go) begin
            host_ready <= 1'b1;
            host_rdata <= host_we ? '0 : reg_view;
        end else if (mem_done) begin
            host_ready <= 1'b1;
            host_rdata <= mem_rd_data;
        end else if (prph_done) begin
            host_ready <= 1'b1;
            host_rdata <= prph_rd_data;
        end else begin
            host_ready <= 1'b0;
        end
    end

    imw_ptr #(.W(DW), .STEP(4)) u_rptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_rptr),
        .load_val (host_wdata),
        .advance  (mem_rd_go),
        .ptr      (rptr)
    );

    imw_ptr #(.W(DW), .STEP(4)) u_wptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_wptr),
        .load_val (host_wdata),
        .advance  (mem_wr_go),
        .ptr      (wptr)
    );

    imw_mem_seq #(.AW(MEM_AW), .DW(DW)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_start   (mem_rd_go),
        .wr_start   (mem_wr_go),
        .rd_word    (rptr[WMSB:WLSB]),
        .wr_word    (wptr[WMSB:WLSB]),
        .wr_data    (host_wdata),
        .busy       (mem_busy),
        .done       (mem_done),
        .rd_data    (mem_rd_data),
        .sram_en    (sram_en),
        .sram_we    (sram_we),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata)
    );

    imw_prph_seq #(.OW(PRPH_OW), .DW(DW)) u_prph (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (pr_wr_go || pr_rd_go),
        .is_write   (pr_wr_go),
        .off        (pr_wr_go ? pw_off : pr_off),
        .cnt        (pr_wr_go ? pw_cnt : pr_cnt),
        .wdata      (host_wdata),
        .busy       (prph_busy),
        .done       (prph_done),
        .rd_data    (prph_rd_data),
        .prph_req   (prph_req),
        .prph_we    (prph_we),
        .prph_addr  (prph_addr),
        .prph_be    (prph_be),
        .prph_wdata (prph_wdata),
        .prph_ack   (prph_ack),
        .prph_rdata (prph_rdata)
    );

    assert_one_port_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_en, prph_req}));

    assert_reg_access_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        simple_go |=> host_ready);

    assert_mem_read_not_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_go |=> (!host_ready && sram_en));

    assert_wptr_untouched_by_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_go && !ld_wptr) |=> $stable(wptr));

endmodule

// File: tb/idx_mem_window_bench.sv
// Bench: behavioural SRAM and peripheral models plus a reference of the
// pointers and contents. Each host access is followed cycle by cycle until
// host_ready, and the arrival cycle and returned data are compared.
module idx_mem_window_bench;
    import imw_pkg::*;

    localparam int AW = 10;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0, host_we = 1'b0;
    logic [2:0]    host_sel = '0;
    logic [31:0]   host_wdata = '0;
    logic          host_ready;
    logic [31:0]   host_rdata;
    logic          sram_en, sram_we;
    logic [AW-1:0] sram_addr;
    logic [31:0]   sram_wdata;
    logic [31:0]   sram_rdata = '0;
    logic          prph_req, prph_we;
    logic [OW-1:0] prph_addr;
    logic [3:0]    prph_be;
    logic [31:0]   prph_wdata;
    logic          prph_ack = 1'b0;
    logic [31:0]   prph_rdata = '0;

    int checks = 0;
    int bad = 0;

    always #5 clk = ~clk;

    idx_mem_window #(.MEM_AW(AW), .PRPH_OW(OW)) u_idx_mem_window (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .sram_en(sram_en), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .prph_req(prph_req), .prph_we(prph_we), .prph_addr(prph_addr),
        .prph_be(prph_be), .prph_wdata(prph_wdata), .prph_ack(prph_ack),
        .prph_rdata(prph_rdata)
    );

    // Device models
    logic [31:0] smem [0:(1<<AW)-1];
    logic [31:0] pmem [0:255];
    int pwait = 0;
    int pcnt = 0;

    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) smem[sram_addr] <= sram_wdata;
            else         sram_rdata      <= smem[sram_addr];
        end
    end

    always @(posedge clk) begin
        if (prph_req && !prph_ack) begin
            if (pcnt == pwait) begin
                prph_ack <= 1'b1;
                pcnt     <= 0;
                if (prph_we) begin
                    for (int k = 0; k < 4; k++)
                        if (prph_be[k]) pmem[prph_addr[7:0]][8*k +: 8] <= prph_wdata[8*k +: 8];
                end else begin
                    prph_rdata <= pmem[prph_addr[7:0]];
                end
            end else begin
                pcnt <= pcnt + 1;
            end
        end else begin
            prph_ack <= 1'b0;
        end
    end

    // Port monitors, sampled away from the clock edge
    int sram_hits = 0;
    logic [AW-1:0] seen_saddr;
    logic seen_swe;
    logic [31:0] seen_swdata;
    int prph_hits = 0;
    logic [OW-1:0] seen_poff;
    logic [3:0] seen_pbe;
    logic seen_pwe;

    always @(negedge clk) begin
        if (sram_en) begin
            sram_hits++;
            seen_saddr  = sram_addr;
            seen_swe    = sram_we;
            seen_swdata = sram_wdata;
        end
        if (prph_req && !prph_ack && pcnt == 0) begin
            prph_hits++;
            seen_poff = prph_addr;
            seen_pbe  = prph_be;
            seen_pwe  = prph_we;
        end
    end

    // Reference state
    logic [31:0] exp_mem [0:(1<<AW)-1];
    logic [31:0] exp_pmem [0:255];
    logic [31:0] rptr_m = '0, wptr_m = '0;
    logic [OW-1:0] pw_off_m = '0, pr_off_m = '0;
    logic [1:0] pw_cnt_m = '0, pr_cnt_m = '0;

    function automatic logic [3:0] ref_lanes(input logic [1:0] c);
        case (c)
            2'd0: return 4'b0001;
            2'd1: return 4'b0011;
            2'd2: return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One host access: drive at a negedge, follow until host_ready
    task automatic host_op(input logic [2:0] sel, input logic we, input logic [31:0] wd,
                           input int lat, input logic chk, input logic [31:0] exp,
                           input string tag);
        int got;
        got = -1;
        host_req = 1'b1; host_sel = sel; host_we = we; host_wdata = wd;
        for (int c = 1; c <= lat + 6; c++) begin
            @(negedge clk);
            host_req = 1'b0;
            if (host_ready) begin got = c; break; end
        end
        expect_eq({tag, " ready cycle"}, got, lat);
        if (chk) expect_eq({tag, " data"}, host_rdata, exp);
    endtask

    task automatic mem_write(input logic [31:0] d, input string tag);
        int h0;
        logic [AW-1:0] w;
        h0 = sram_hits;
        w = wptr_m[AW+1:2];
        host_op(SEL_MEM_WDATA, 1'b1, d, 2, 1'b0, '0, tag);
        expect_eq({tag, " sram write count"}, sram_hits - h0, 1);
        expect_eq({tag, " sram write addr"}, {22'd0, seen_saddr}, {22'd0, w});
        expect_eq({tag, " sram write data"}, seen_swdata, d);
        exp_mem[w] = d;
        wptr_m = wptr_m + 32'd4;
    endtask

    task automatic mem_read(input string tag);
        int h0;
        logic [AW-1:0] w;
        h0 = sram_hits;
        w = rptr_m[AW+1:2];
        host_op(SEL_MEM_RDATA, 1'b0, '0, 3, 1'b1, exp_mem[w], tag);
        expect_eq({tag, " sram read count"}, sram_hits - h0, 1);
        expect_eq({tag, " sram read addr"}, {22'd0, seen_saddr}, {22'd0, w});
        rptr_m = rptr_m + 32'd4;
    endtask

    task automatic prph_write(input logic [31:0] d, input int wt);
        int h0;
        h0 = prph_hits;
        pwait = wt;
        host_op(SEL_PRPH_WDATA, 1'b1, d, 3 + wt, 1'b0, '0, "R8 prph write");
        expect_eq("R8 request count", prph_hits - h0, 1);
        expect_eq("R8 offset", {16'd0, seen_poff}, {16'd0, pw_off_m});
        expect_eq("R8 byte enables", {28'd0, seen_pbe}, {28'd0, ref_lanes(pw_cnt_m)});
        expect_eq("R8 write flag", {31'd0, seen_pwe}, 32'd1);
        for (int k = 0; k < 4; k++)
            if (k <= int'(pw_cnt_m)) exp_pmem[pw_off_m[7:0]][8*k +: 8] = d[8*k +: 8];
    endtask

    task automatic prph_read(input int wt);
        pwait = wt;
        host_op(SEL_PRPH_RDATA, 1'b0, '0, 3 + wt, 1'b1, exp_pmem[pr_off_m[7:0]], "R9 prph read");
        expect_eq("R9 offset", {16'd0, seen_poff}, {16'd0, pr_off_m});
        expect_eq("R9 byte enables", {28'd0, seen_pbe}, {28'd0, ref_lanes(pr_cnt_m)});
        expect_eq("R9 write flag", {31'd0, seen_pwe}, 32'd0);
    endtask

    task automatic set_rptr(input logic [31:0] v);
        host_op(SEL_MEM_RPTR, 1'b1, v, 1, 1'b0, '0, "R2 load rptr");
        rptr_m = v;
    endtask

    task automatic set_wptr(input logic [31:0] v);
        host_op(SEL_MEM_WPTR, 1'b1, v, 1, 1'b0, '0, "R2 load wptr");
        wptr_m = v;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int h0;
        for (int i = 0; i < (1 << AW); i++) begin smem[i] = '0; exp_mem[i] = '0; end
        for (int i = 0; i < 256; i++) begin pmem[i] = '0; exp_pmem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_eq("R1 host_ready", {31'd0, host_ready}, 32'd0);
        expect_eq("R1 sram_en", {31'd0, sram_en}, 32'd0);
        expect_eq("R1 prph_req", {31'd0, prph_req}, 32'd0);
        host_op(SEL_MEM_RPTR, 1'b0, '0, 1, 1'b1, 32'd0, "R1 rptr after reset");
        host_op(SEL_MEM_WPTR, 1'b0, '0, 1, 1'b1, 32'd0, "R1 wptr after reset");

        // R2: pointer registers hold full 32 bits
        set_rptr(32'hABCD_0123);
        host_op(SEL_MEM_RPTR, 1'b0, '0, 1, 1'b1, 32'hABCD_0123, "R2 rptr readback");
        set_wptr(32'h0000_0100);
        host_op(SEL_MEM_WPTR, 1'b0, '0, 1, 1'b1, 32'h0000_0100, "R2 wptr readback");

        // R3: streaming writes
        mem_write(32'h1111_0001, "R3 write 0");
        mem_write(32'h2222_0002, "R3 write 1");
        mem_write(32'h3333_0003, "R3 write 2");
        mem_write(32'h4444_0004, "R3 write 3");
        host_op(SEL_MEM_WPTR, 1'b0, '0, 1, 1'b1, 32'h0000_0110, "R3 wptr advanced");

        // R4: streaming reads
        set_rptr(32'h0000_0100);
        mem_read("R4 read 0");
        mem_read("R4 read 1");
        mem_read("R4 read 2");
        host_op(SEL_MEM_RPTR, 1'b0, '0, 1, 1'b1, 32'h0000_010C, "R4 rptr advanced");

        // R5: interleaved accesses with independent pointers
        mem_write(32'h5555_0005, "R5 write a");
        mem_read("R5 read a");
        mem_write(32'h6666_0006, "R5 write b");
        mem_read("R5 read b");
        host_op(SEL_MEM_WPTR, 1'b0, '0, 1, 1'b1, wptr_m, "R5 wptr");
        host_op(SEL_MEM_RPTR, 1'b0, '0, 1, 1'b1, rptr_m, "R5 rptr");
        set_rptr(32'h0000_0110);
        mem_read("R5 read written a");
        mem_read("R5 read written b");

        // R6: low address bits ignored, wrap at top of range
        set_wptr(32'h0000_0013);
        mem_write(32'hCAFE_0013, "R6 unaligned write");
        host_op(SEL_MEM_WPTR, 1'b0, '0, 1, 1'b1, 32'h0000_0017, "R6 wptr keeps low bits");
        set_rptr(32'h0000_0012);
        mem_read("R6 unaligned read");
        set_wptr(32'hFFFF_FFFC);
        mem_write(32'hDEAD_BEEF, "R6 top write");
        host_op(SEL_MEM_WPTR, 1'b0, '0, 1, 1'b1, 32'h0000_0000, "R6 wptr wraps");
        set_rptr(32'hFFFF_FFFC);
        mem_read("R6 top read");
        host_op(SEL_MEM_RPTR, 1'b0, '0, 1, 1'b1, 32'h0000_0000, "R6 rptr wraps");

        // R10: ignored accesses
        h0 = sram_hits;
        host_op(SEL_MEM_RDATA, 1'b1, 32'h1234_5678, 1, 1'b0, '0, "R10 write rdata reg");
        expect_eq("R10 no sram access", sram_hits - h0, 0);
        host_op(SEL_MEM_RPTR, 1'b0, '0, 1, 1'b1, 32'h0000_0000, "R10 rptr unchanged");
        host_op(SEL_MEM_WDATA, 1'b0, '0, 1, 1'b1, 32'h0000_0000, "R10 read wdata reg");
        expect_eq("R10 no sram access after read", sram_hits - h0, 0);
        host_op(SEL_MEM_WPTR, 1'b0, '0, 1, 1'b1, 32'h0000_0000, "R10 wptr unchanged");
        h0 = prph_hits;
        host_op(SEL_PRPH_RDATA, 1'b1, 32'hFFFF_FFFF, 1, 1'b0, '0, "R10 write prph rdata reg");
        host_op(SEL_PRPH_WDATA, 1'b0, '0, 1, 1'b1, 32'h0000_0000, "R10 read prph wdata reg");
        expect_eq("R10 no prph access", prph_hits - h0, 0);

        // R7: peripheral address field masking
        host_op(SEL_PRPH_WADDR, 1'b1, 32'hFFFF_1234, 1, 1'b0, '0, "R7 load waddr");
        host_op(SEL_PRPH_WADDR, 1'b0, '0, 1, 1'b1, 32'h0300_1234, "R7 waddr readback");
        host_op(SEL_PRPH_RADDR, 1'b1, 32'h0100_0020, 1, 1'b0, '0, "R7 load raddr");
        host_op(SEL_PRPH_RADDR, 1'b0, '0, 1, 1'b1, 32'h0100_0020, "R7 raddr readback");

        // R8: writes with every byte count and varied acknowledge delay
        host_op(SEL_PRPH_WADDR, 1'b1, 32'h0300_0020, 1, 1'b0, '0, "R8 waddr cnt3");
        pw_off_m = 16'h0020; pw_cnt_m = 2'd3;
        prph_write(32'hFFFF_FFFF, 0);
        for (int c = 0; c < 3; c++) begin
            host_op(SEL_PRPH_WADDR, 1'b1, {6'd0, 2'(c), 8'd0, 16'h0020}, 1, 1'b0, '0, "R8 waddr cnt");
            pw_cnt_m = 2'(c);
            prph_write(32'h0000_0000 | (32'h11 << (8 * c)), c);
        end

        // R9: reads back with two count settings and delays
        pr_off_m = 16'h0020; pr_cnt_m = 2'd1;
        prph_read(2);
        host_op(SEL_PRPH_RADDR, 1'b1, 32'h0300_0020, 1, 1'b0, '0, "R9 raddr cnt3");
        pr_cnt_m = 2'd3;
        prph_read(0);
        host_op(SEL_PRPH_RADDR, 1'b1, 32'h0000_0045, 1, 1'b0, '0, "R9 raddr other");
        pr_off_m = 16'h0045; pr_cnt_m = 2'd0;
        prph_read(1);

        finish_run();
    end

endmodule